// File: doc/BRIEF.md
# Predicated Three-Way Interleaving Store

This block turns one three-operand vector store command into a stream of single-word memory writes. It receives three vectors of 32-bit elements as wide buses, a byte-granular predicate, a 64-bit base and a 64-bit word index. It then emits words so that element i of the first, second and third vector land in three adjacent word slots. Successive elements follow one after another with no gaps.

The starting byte address is `base + (index << 2)`. An element whose governing predicate bit is clear produces no write at all, so the memory it would have covered keeps its contents and cannot raise a fault. Writes go out one at a time on a valid/ready port. An error response on any accepted write stops the command and reports the element that faulted.

The controller has three states:
- `ST_IDLE` waits for `start_i`.
- `ST_ISSUE` presents one word per cycle. It leaves on the last word of the last active element, or on an error.
- `ST_FINISH` raises `done_o` for one cycle, then returns to `ST_IDLE`.

A start that finds no active element goes straight from `ST_IDLE` to `ST_FINISH`.

Top module: `tri_interleave_store`

## Requirements
- R1: The word from vector r (r=0 for `vec_a_i`, 1 for `vec_b_i`, 2 for `vec_c_i`) at element i is written at byte address `base_i + (index_i << 2) + 4*(3*i + r)`. Its data is bits `[32*i+31:32*i]` of that vector.
- R2: Element i is active when `pred_i[4*i]` is 1. The other predicate bits have no effect. An inactive element produces none of its three writes.
- R3: Accepted writes come out in strictly ascending address order, at most one per cycle.
- R4: While `wr_valid_o` is high and `wr_ready_i` is low, the next cycle still has `wr_valid_o` high with unchanged `wr_addr_o` and `wr_data_o`.
- R5: If no element is active, `done_o` is high in the cycle right after the `start_i` cycle, no write is issued, and `fault_o` is low.
- R6: `wr_err_i` is sampled in a cycle where `wr_valid_o` and `wr_ready_i` are both high. If it is set, no further write is issued, and the next cycle shows `done_o`, `fault_o`=1 and `fault_elem_o` equal to that word's element index.
- R7: After the third word of the last active element is accepted without error, `done_o` is high for exactly one cycle in the next cycle, with `fault_o`=0.
- R8: After reset `busy_o`, `done_o` and `wr_valid_o` are low. `busy_o` is high from the cycle after an accepted start through the `done_o` cycle. A `start_i` while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Command start, taken when busy_o is low |
| base_i | input | 64 | Scalar base byte address |
| index_i | input | 64 | Scalar word index |
| vec_a_i | input | VLEN | First source vector |
| vec_b_i | input | VLEN | Second source vector |
| vec_c_i | input | VLEN | Third source vector |
| pred_i | input | VLEN/8 | Byte predicate; bit 4*i governs element i |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | With done_o: command ended on a write error |
| fault_elem_o | output | log2(VLEN/32) | With fault_o: element index of the failed write |
| wr_valid_o | output | 1 | Word write valid |
| wr_ready_i | input | 1 | Word write accepted |
| wr_addr_o | output | 64 | Word write byte address |
| wr_data_o | output | 32 | Word write data |
| wr_err_i | input | 1 | Error response for the write accepted this cycle |

## Verification
The bound checker watches the port-level rules on every cycle:
- stability under back-pressure,
- strictly rising addresses within a command,
- silence and a fault-flagged done after an error,
- the single-cycle done pulse,
- the immediate done for an empty predicate.

Only the bench scenarios can show the rest. Those cover the exact address and data of every word, the omission of inactive elements and the unused predicate bits, the reported fault element, and the rejection of a start issued mid-command. They compare the write stream against a queue computed from the requirements.

// File: rtl/tis_pkg.sv
package tis_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_FINISH = 2'd2
    } tis_state_e;

    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 64;
    localparam int N_SRC   = 3;
endpackage

// File: rtl/tis_first_set.sv
module tis_first_set #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  mask_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (mask_i[k]) begin
                any_o = 1'b1;
                idx_o = IW'(k);
            end
        end
    end
endmodule

// File: rtl/tis_word_mux.sv
module tis_word_mux #(
    parameter int NELEM = 4,
    parameter int EW    = 32,
    parameter int IW    = 2
) (
    input  logic [NELEM*EW-1:0] src0_i,
    input  logic [NELEM*EW-1:0] src1_i,
    input  logic [NELEM*EW-1:0] src2_i,
    input  logic [IW-1:0]       elem_i,
    input  logic [1:0]          lane_i,
    output logic [EW-1:0]       word_o
);
    logic [EW-1:0] e0 [NELEM];
    logic [EW-1:0] e1 [NELEM];
    logic [EW-1:0] e2 [NELEM];

    for (genvar g = 0; g < NELEM; g++) begin : g_split
        assign e0[g] = src0_i[g*EW +: EW];
        assign e1[g] = src1_i[g*EW +: EW];
        assign e2[g] = src2_i[g*EW +: EW];
    end

    always_comb begin
        unique case (lane_i)
            2'd0:    word_o = e0[elem_i];
            2'd1:    word_o = e1[elem_i];
            default: word_o = e2[elem_i];
        endcase
    end
endmodule

// File: rtl/tis_addr_gen.sv
module tis_addr_gen #(
    parameter int IW = 2
) (
    input  logic [63:0]   first_addr_i,
    input  logic [IW-1:0] elem_i,
    input  logic [1:0]    lane_i,
    output logic [63:0]   addr_o
);
    logic [63:0] word_off;

    always_comb begin
        word_off = (64'(elem_i) * 64'd3) + 64'(lane_i);
        addr_o   = first_addr_i + (word_off << 2);
    end
endmodule

// File: rtl/tri_interleave_store.sv
module tri_interleave_store
    import tis_pkg::*;
#(
    parameter int VLEN = 128,
    localparam int NELEM  = VLEN / WORD_W,
    localparam int PRED_W = VLEN / 8,
    localparam int IW     = (NELEM > 1) ? $clog2(NELEM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [63:0]       base_i,
    input  logic [63:0]       index_i,
    input  logic [VLEN-1:0]   vec_a_i,
    input  logic [VLEN-1:0]   vec_b_i,
    input  logic [VLEN-1:0]   vec_c_i,
    input  logic [PRED_W-1:0] pred_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fault_o,
    output logic [IW-1:0]     fault_elem_o,
    output logic              wr_valid_o,
    input  logic              wr_ready_i,
    output logic [63:0]       wr_addr_o,
    output logic [31:0]       wr_data_o,
    input  logic              wr_err_i
);
    localparam logic [1:0] LAST_LANE = 2'(N_SRC - 1);

    tis_state_e state_q, state_d;

    logic [VLEN-1:0]  src0_q, src1_q, src2_q;
    logic [NELEM-1:0] pending_q;
    logic [NELEM-1:0] pred_elem;
    logic [NELEM-1:0] cur_onehot;
    logic [NELEM-1:0] seek_mask;
    logic [IW-1:0]    elem_q;
    logic [1:0]       lane_q;
    logic [63:0]      first_addr_q;
    logic             fault_q;
    logic [IW-1:0]    fault_elem_q;
    logic             seek_any;
    logic [IW-1:0]    seek_idx;
    logic             accept;
    logic             last_word;

    // Governing bit of each element is the low bit of its byte group.
    for (genvar g = 0; g < NELEM; g++) begin : g_pred
        assign pred_elem[g] = pred_i[4*g];
    end

    assign cur_onehot = NELEM'(1) << elem_q;
    assign seek_mask  = (state_q == ST_IDLE) ? pred_elem : (pending_q & ~cur_onehot);
    assign accept     = wr_valid_o && wr_ready_i;
    assign last_word  = (lane_q == LAST_LANE);

    tis_first_set #(.N(NELEM), .IW(IW)) u_seek (
        .mask_i (seek_mask),
        .any_o  (seek_any),
        .idx_o  (seek_idx)
    );

    tis_word_mux #(.NELEM(NELEM), .EW(WORD_W), .IW(IW)) u_mux (
        .src0_i (src0_q),
        .src1_i (src1_q),
        .src2_i (src2_q),
        .elem_i (elem_q),
        .lane_i (lane_q),
        .word_o (wr_data_o)
    );

    tis_addr_gen #(.IW(IW)) u_addr (
        .first_addr_i (first_addr_q),
        .elem_i       (elem_q),
        .lane_i       (lane_q),
        .addr_o       (wr_addr_o)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = seek_any ? ST_ISSUE : ST_FINISH;
            end
            ST_ISSUE: begin
                if (accept && wr_err_i)                    state_d = ST_FINISH;
                else if (accept && last_word && !seek_any) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and command context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            src0_q       <= '0;
            src1_q       <= '0;
            src2_q       <= '0;
            pending_q    <= '0;
            elem_q       <= '0;
            lane_q       <= '0;
            first_addr_q <= '0;
            fault_q      <= 1'b0;
            fault_elem_q <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        src0_q       <= vec_a_i;
                        src1_q       <= vec_b_i;
                        src2_q       <= vec_c_i;
                        pending_q    <= pred_elem;
                        elem_q       <= seek_idx;
                        lane_q       <= '0;
                        first_addr_q <= base_i + (index_i << 2);
                        fault_q      <= 1'b0;
                        fault_elem_q <= '0;
                    end
                end
                ST_ISSUE: begin
                    if (accept) begin
                        if (wr_err_i) begin
                            fault_q      <= 1'b1;
                            fault_elem_q <= elem_q;
                        end else if (!last_word) begin
                            lane_q <= lane_q + 2'd1;
                        end else begin
                            lane_q    <= '0;
                            pending_q <= seek_mask;
                            elem_q    <= seek_idx;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        done_o       = (state_q == ST_FINISH);
        wr_valid_o   = (state_q == ST_ISSUE);
        fault_o      = done_o && fault_q;
        fault_elem_o = fault_elem_q;
    end
endmodule

// File: rtl/tis_checker.sv
module tis_checker #(
    parameter int PRED_W = 16,
    parameter int NELEM  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [PRED_W-1:0] pred_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              fault_o,
    input logic              wr_valid_o,
    input logic              wr_ready_i,
    input logic [63:0]       wr_addr_o,
    input logic [31:0]       wr_data_o,
    input logic              wr_err_i
);
    logic             have_last_q;
    logic [63:0]      last_addr_q;
    logic [NELEM-1:0] gov;
    logic             taken;
    logic             accept;

    for (genvar g = 0; g < NELEM; g++) begin : g_gov
        assign gov[g] = pred_i[4*g];
    end

    assign taken  = start_i && !busy_o;
    assign accept = wr_valid_o && wr_ready_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_last_q <= 1'b0;
            last_addr_q <= '0;
        end else if (taken) begin
            have_last_q <= 1'b0;
        end else if (accept) begin
            have_last_q <= 1'b1;
            last_addr_q <= wr_addr_o;
        end
    end

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)); // R4

    AST_ADDR_RISING: assert property (@(posedge clk) disable iff (!rst_n)
        accept && have_last_q |-> wr_addr_o > last_addr_q); // R3

    AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        taken && (gov == '0) |=> done_o && !fault_o && !wr_valid_o); // R5

    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        accept && wr_err_i |=> done_o && fault_o && !wr_valid_o); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_VALID_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> busy_o); // R8
endmodule

bind tri_interleave_store tis_checker #(.PRED_W(PRED_W), .NELEM(NELEM)) u_tis_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .pred_i     (pred_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fault_o    (fault_o),
    .wr_valid_o (wr_valid_o),
    .wr_ready_i (wr_ready_i),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .wr_err_i   (wr_err_i)
);

// File: tb/tri_interleave_store_tb_top.sv
module tri_interleave_store_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int VLEN   = 128;
    localparam int NELEM  = VLEN / 32;
    localparam int PRED_W = VLEN / 8;
    localparam int IW     = $clog2(NELEM);

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
    } wr_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [63:0]       base_i = '0;
    logic [63:0]       index_i = '0;
    logic [VLEN-1:0]   vec_a_i = '0;
    logic [VLEN-1:0]   vec_b_i = '0;
    logic [VLEN-1:0]   vec_c_i = '0;
    logic [PRED_W-1:0] pred_i = '0;
    logic              busy_o, done_o, fault_o;
    logic [IW-1:0]     fault_elem_o;
    logic              wr_valid_o;
    logic              wr_ready_i = 1'b0;
    logic [63:0]       wr_addr_o;
    logic [31:0]       wr_data_o;
    logic              wr_err_i = 1'b0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    wr_item_t exp_q[$];
    int  accepts = 0;
    int  err_at = -1;
    int  stall_mode = 0;
    int  cyc = 0;
    bit  have_last = 0;
    logic [63:0] last_addr = '0;
    bit  prev_stall = 0;
    logic [63:0] prev_addr = '0;
    logic [31:0] prev_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_interleave_store #(.VLEN(VLEN)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .base_i       (base_i),
        .index_i      (index_i),
        .vec_a_i      (vec_a_i),
        .vec_b_i      (vec_b_i),
        .vec_c_i      (vec_c_i),
        .pred_i       (pred_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .fault_o      (fault_o),
        .fault_elem_o (fault_elem_o),
        .wr_valid_o   (wr_valid_o),
        .wr_ready_i   (wr_ready_i),
        .wr_addr_o    (wr_addr_o),
        .wr_data_o    (wr_data_o),
        .wr_err_i     (wr_err_i)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Ready and error response driver
    always @(posedge clk) begin
        #1;
        cyc++;
        case (stall_mode)
            0:       wr_ready_i = 1'b1;
            1:       wr_ready_i = (cyc % 3) != 0;
            default: wr_ready_i = (cyc % 2) != 0;
        endcase
        wr_err_i = (err_at >= 0) && (accepts == err_at);
    end

    // Monitor: pops and compares every accepted write
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                check(wr_valid_o && wr_addr_o == prev_addr && wr_data_o == prev_data,
                      "R4", "held word", {32'h0, wr_data_o}, {32'h0, prev_data});
            end
            prev_stall = wr_valid_o && !wr_ready_i;
            prev_addr  = wr_addr_o;
            prev_data  = wr_data_o;
            if (wr_valid_o && wr_ready_i) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected write", wr_addr_o, 64'h0);
                end else begin
                    wr_item_t e;
                    e = exp_q.pop_front();
                    check(wr_addr_o == e.addr, "R1", "write address", wr_addr_o, e.addr);
                    check(wr_data_o == e.data, "R1", "write data",
                          {32'h0, wr_data_o}, {32'h0, e.data});
                end
                if (have_last)
                    check(wr_addr_o > last_addr, "R3", "ascending address", wr_addr_o, last_addr);
                have_last = 1;
                last_addr = wr_addr_o;
                accepts++;
            end
        end
    end

    function automatic logic [31:0] elem_val(input int seed, input int r, input int i);
        return {16'(seed), 8'(8'hA0 + r), 8'(i)};
    endfunction

    task automatic run_cmd(input logic [63:0] base, input logic [63:0] idx, input int seed,
                           input logic [PRED_W-1:0] pred, input int fail_at, input int smode,
                           input bit poke, input string tag);
        logic [VLEN-1:0] va, vb, vc;
        logic [63:0] first;
        bit exp_fault = 0;
        logic [IW-1:0] exp_fe = '0;
        int n = 0;
        int wait_cyc = 0;
        for (int i = 0; i < NELEM; i++) begin
            va[i*32 +: 32] = elem_val(seed, 0, i);
            vb[i*32 +: 32] = elem_val(seed, 1, i);
            vc[i*32 +: 32] = elem_val(seed, 2, i);
        end
        first = base + (idx << 2);
        exp_q.delete();
        for (int i = 0; i < NELEM; i++) begin
            if (pred[4*i]) begin
                for (int r = 0; r < 3; r++) begin
                    if (fail_at < 0 || n <= fail_at) begin
                        wr_item_t it;
                        it.addr = first + 64'(4 * (3*i + r));
                        it.data = (r == 0) ? va[i*32 +: 32] : (r == 1) ? vb[i*32 +: 32] : vc[i*32 +: 32];
                        exp_q.push_back(it);
                        if (n == fail_at) begin
                            exp_fault = 1;
                            exp_fe = IW'(i);
                        end
                    end
                    n++;
                end
            end
        end
        @(posedge clk); #2;
        accepts = 0; err_at = fail_at; stall_mode = smode; have_last = 0; prev_stall = 0;
        base_i = base; index_i = idx; vec_a_i = va; vec_b_i = vb; vec_c_i = vc; pred_i = pred;
        start_i = 1'b1;
        @(posedge clk); #2;
        start_i = 1'b0;
        if (poke) begin
            @(posedge clk); #2;
            base_i = 64'hDEAD_0000; pred_i = '1; vec_a_i = '0; start_i = 1'b1;
            @(negedge clk);
            check(busy_o == 1'b1, "R8", "busy during command", {63'h0, busy_o}, 64'h1);
            @(posedge clk); #2;
            start_i = 1'b0;
        end
        forever begin
            @(negedge clk);
            if (done_o || wait_cyc > 2000) break;
            check(busy_o == 1'b1, "R8", "busy until done", {63'h0, busy_o}, 64'h1);
            wait_cyc++;
        end
        check(done_o == 1'b1, tag, "done reached", {63'h0, done_o}, 64'h1);
        check(fault_o == exp_fault, exp_fault ? "R6" : "R7", "fault flag",
              {63'h0, fault_o}, {63'h0, exp_fault});
        if (exp_fault)
            check(fault_elem_o == exp_fe, "R6", "fault element",
                  64'(fault_elem_o), 64'(exp_fe));
        check(exp_q.size() == 0, tag, "writes left over", 64'(exp_q.size()), 64'h0);
        if (n == 0) begin
            check(wait_cyc == 0, "R5", "done one cycle after start", 64'(wait_cyc), 64'h0);
            check(accepts == 0, "R5", "no writes", 64'(accepts), 64'h0);
        end
        @(negedge clk);
        check(done_o == 1'b0 && busy_o == 1'b0, "R7", "single done pulse",
              {62'h0, done_o, busy_o}, 64'h0);
        err_at = -1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && !wr_valid_o, "R8", "reset state",
              {61'h0, busy_o, done_o, wr_valid_o}, 64'h0);

        // R1: all elements active, back-to-back acceptance
        run_cmd(64'h1000, 64'h3, 16'h1234, 16'h1111, -1, 0, 0, "R1");
        // R2: only elements 1 and 3, non-governing bits set
        run_cmd(64'h4000, 64'h0, 16'h5a5a, 16'hFEFE, -1, 0, 0, "R2");
        // R4: stalls on a sparse predicate
        run_cmd(64'h8000, 64'h10, 16'h0042, 16'h0101, -1, 1, 0, "R4");
        // R5: no governing bit set
        run_cmd(64'h9000, 64'h1, 16'h0077, 16'hEEEE, -1, 0, 0, "R5");
        // R6: error on word 4 (element 1, second vector)
        run_cmd(64'hA000, 64'h2, 16'h0BAD, 16'h1111, 4, 1, 0, "R6");
        // R6: error on the first write of element 3
        run_cmd(64'hB000, 64'h0, 16'h0C0C, 16'h1000, 0, 0, 0, "R6");
        // R8: a start while busy is ignored
        run_cmd(64'hC000, 64'h5, 16'h0E0E, 16'h0011, -1, 2, 1, "R8");
        // R1: large base and index
        run_cmd(64'h0000_2000_0000_0000, 64'h100, 16'h7777, 16'h1111, -1, 2, 0, "R1");

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule